// File: doc/BRIEF.md
# Change-of-State Interrupt Controller

This block gathers six line-status level conditions and two elastic-store event pulses (overflow and underflow) and folds them into one interrupt request toward a host processor. Each level condition is watched for a change in either direction; each event pulse counts by its mere occurrence. Any such cause sets a sticky pending flag, and the interrupt pin is pulled low while any flag is set. The pin is modelled as an open-drain enable: the block only ever asks the pad to pull low or to let go.

The host learns the cause through a status register. It holds the present level of every condition and the pending flags of the two event causes. A second register serves as both clear and mask. A one written to a bit discards that cause's pending flag and blocks the cause. A zero written to the bit unblocks it. While a cause is blocked its changes are dropped, not saved, so unblocking never produces a stale interrupt. Reading the second register returns the mask.

Top module: `cos_irq_ctrl`

## Requirements
- R1: A change of any condition input in either direction, with its mask bit at 0, sets that cause pending at the next clock edge.
- R2: A one-cycle high pulse on the overflow or underflow event input, with its mask bit at 0, sets that cause pending at the next clock edge. Overflow is cause bit 6 and underflow is cause bit 7. Status bit 6 reads the overflow pending flag and status bit 7 reads the underflow pending flag.
- R3: `irq_pull_low` is 1 exactly when at least one cause is pending and 0 otherwise; there is no other output state.
- R4: A pending flag stays set across later cycles, including after its condition returns to its former level, until the host clears it.
- R5: Writing the clear/mask register (address 1) with bit i = 1 clears pending cause i at that edge and masks it. A masked cause ignores changes and events. After it is unmasked, no interrupt appears for activity that occurred while it was masked.
- R6: Writing bit i = 0 to the clear/mask register unmasks cause i. A change occurring one cycle or more after that write is latched again.
- R7: A read at address 0 returns the live condition levels on bits 5:0, the overflow pending flag on bit 6 and the underflow pending flag on bit 7. A read at address 1 returns the mask. Read data is combinational from `reg_addr`.
- R8: Reset clears all mask bits and pending flags and loads the current condition levels as the reference. Nonzero condition levels at reset release raise no interrupt.
- R9: When a write of 1 to a mask bit and a change or event of that same cause fall in the same cycle, the clear wins and the cause is not pending afterwards. A change on a different, unmasked cause in that same cycle is still latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cond_i | input | 6 | Monitored line-status condition levels |
| ovf_evt_i | input | 1 | Elastic-store overflow event pulse |
| unf_evt_i | input | 1 | Elastic-store underflow event pulse |
| reg_addr | input | 1 | Register select: 0 status, 1 clear/mask |
| reg_wr | input | 1 | Write strobe, effective at the clock edge |
| reg_wdata | input | 8 | Write data for the clear/mask register |
| reg_rdata | output | 8 | Read data for the selected register |
| irq_pull_low | output | 1 | Open-drain enable: 1 pulls the interrupt line low |

## Verification
The two functions that can share a cycle are a host write to the clear/mask register and the arrival of a cause's change or event. The bench provokes this for each of the eight causes by toggling the condition, or pulsing the event, in exactly the cycle the mask-setting write is presented. It then judges at the outputs that the interrupt stays released and that the status event flags stay clear. A second case pairs the write to one cause with a change on another. There the interrupt must still rise, proving that the clear is confined to the written bits.

// File: rtl/cos_irq_ctrl.sv
module cos_irq_ctrl #(
  parameter int NUM_COND = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_COND-1:0]   cond_i,
  input  logic                  ovf_evt_i,
  input  logic                  unf_evt_i,
  input  logic                  reg_addr,
  input  logic                  reg_wr,
  input  logic [NUM_COND+1:0]   reg_wdata,
  output logic [NUM_COND+1:0]   reg_rdata,
  output logic                  irq_pull_low
);

  localparam int NCAUSE = NUM_COND + 2;
  localparam int OVF_BIT = NUM_COND;
  localparam int UNF_BIT = NUM_COND + 1;

  logic [NUM_COND-1:0] ref_q;
  logic [NCAUSE-1:0]   mask_q;
  logic [NCAUSE-1:0]   pend_q;

  wire               ctl_wr  = reg_wr && reg_addr;
  wire [NCAUSE-1:0]  clr_vec = ctl_wr ? reg_wdata : '0;
  wire [NCAUSE-1:0]  raw     = {unf_evt_i, ovf_evt_i, cond_i ^ ref_q};
  wire [NCAUSE-1:0]  hit     = raw & ~mask_q;

  always_ff @(posedge clk) begin
    ref_q <= cond_i;
    if (!rst_n) begin
      mask_q <= '0;
      pend_q <= '0;
    end else begin
      if (ctl_wr) mask_q <= reg_wdata;
      pend_q <= (pend_q | hit) & ~clr_vec;
    end
  end

  assign irq_pull_low = |pend_q;
  assign reg_rdata    = reg_addr ? mask_q
                                 : {pend_q[UNF_BIT], pend_q[OVF_BIT], cond_i};

  // R9: a cleared bit is never pending right after the write
  assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> (pend_q & $past(reg_wdata)) == '0);

  // R5: causes masked in the previous cycle cannot become pending
  assert_masked_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pend_q & $past(mask_q)) == '0);

  // R4: pending flags only drop through a host clear
  assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($past(pend_q) & ~$past(clr_vec) & ~pend_q) == '0);

  // R3: interrupt only rises after some cause activity
  assert_irq_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_pull_low) |-> $past(|raw));

  // R8: interrupt released right after reset
  assert_reset_quiet_R8: assert property (@(posedge clk)
    $past(!rst_n) |-> !irq_pull_low);

endmodule

// File: tb/tb_cos_irq_ctrl.sv
module tb_cos_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] cond_i = 6'b101001;
  logic       ovf_evt_i = 1'b0, unf_evt_i = 1'b0;
  logic       reg_addr = 1'b0, reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq_pull_low;

  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cos_irq_ctrl #(.NUM_COND(6)) dut (
    .clk(clk), .rst_n(rst_n), .cond_i(cond_i), .ovf_evt_i(ovf_evt_i),
    .unf_evt_i(unf_evt_i), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_pull_low(irq_pull_low)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic wr_mask(input logic [7:0] d);
    reg_addr = 1'b1; reg_wr = 1'b1; reg_wdata = d;
    tick();
    reg_wr = 1'b0; reg_addr = 1'b0;
  endtask

  task automatic read_status(input string req, input logic [7:0] exp);
    reg_addr = 1'b0; #1;
    chk(req, reg_rdata, exp);
  endtask

  // provoke cause k (0..5 toggles condition, 6 overflow, 7 underflow) without advancing time
  task automatic poke(input int k);
    if (k < 6) cond_i[k] = ~cond_i[k];
    else if (k == 6) ovf_evt_i = 1'b1;
    else unf_evt_i = 1'b1;
  endtask

  task automatic unpoke;
    ovf_evt_i = 1'b0; unf_evt_i = 1'b0;
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R8: reset state with nonzero conditions
    chk("R8 irq after reset", {7'b0, irq_pull_low}, 8'h00);
    read_status("R8 status after reset", {2'b00, cond_i});
    reg_addr = 1'b1; #1;
    chk("R8 mask after reset", reg_rdata, 8'h00);
    reg_addr = 1'b0;

    // R1/R2/R3/R4/R5/R6: sweep every cause, both directions for conditions
    for (int k = 0; k < 8; k++) begin
      for (int pass = 0; pass < 2; pass++) begin
        poke(k); tick(); unpoke();
        chk("R1 R2 irq after cause", {7'b0, irq_pull_low}, 8'h01);
        read_status("R7 status after cause",
                    {(k == 7) ? 1'b1 : 1'b0, (k == 6) ? 1'b1 : 1'b0, cond_i});
        if (k < 6) begin
          cond_i[k] = ~cond_i[k]; tick();
          chk("R4 sticky after return", {7'b0, irq_pull_low}, 8'h01);
          cond_i[k] = ~cond_i[k]; tick();
        end else begin
          repeat (2) tick();
          chk("R4 sticky event", {7'b0, irq_pull_low}, 8'h01);
        end
        wr_mask(8'(1 << k));
        chk("R5 clear drops irq", {7'b0, irq_pull_low}, 8'h00);
        reg_addr = 1'b1; #1;
        chk("R7 mask readback", reg_rdata, 8'(1 << k));
        reg_addr = 1'b0;
        poke(k); tick(); unpoke(); tick();
        chk("R5 masked ignored", {7'b0, irq_pull_low}, 8'h00);
        wr_mask(8'h00);
        tick();
        chk("R5 no stale irq on unmask", {7'b0, irq_pull_low}, 8'h00);
        read_status("R5 status after unmask", {2'b00, cond_i});
      end
    end

    // R6: unmask then a new change is latched
    wr_mask(8'hFF);
    cond_i = ~cond_i; tick();
    chk("R5 all masked", {7'b0, irq_pull_low}, 8'h00);
    wr_mask(8'h00);
    cond_i[3] = ~cond_i[3]; tick();
    chk("R6 reenabled change", {7'b0, irq_pull_low}, 8'h01);
    wr_mask(8'h08); wr_mask(8'h00);
    chk("R6 cleared again", {7'b0, irq_pull_low}, 8'h00);

    // R9: clear and same-cause activity in one cycle
    for (int k = 0; k < 8; k++) begin
      reg_addr = 1'b1; reg_wr = 1'b1; reg_wdata = 8'(1 << k);
      poke(k);
      tick();
      reg_wr = 1'b0; reg_addr = 1'b0; unpoke();
      chk("R9 clear wins same cycle", {7'b0, irq_pull_low}, 8'h00);
      read_status("R9 status event flags", {2'b00, cond_i});
      wr_mask(8'h00);
    end
    // R9: clear of one cause does not swallow another
    reg_addr = 1'b1; reg_wr = 1'b1; reg_wdata = 8'h01;
    cond_i[2] = ~cond_i[2];
    tick();
    reg_wr = 1'b0; reg_addr = 1'b0;
    chk("R9 other cause kept", {7'b0, irq_pull_low}, 8'h01);
    wr_mask(8'h00); wr_mask(8'h04); wr_mask(8'h00);
    chk("R3 released after clear", {7'b0, irq_pull_low}, 8'h00);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule